// File: doc/BRIEF.md
# Boot Image Acceptance Sequencer with Key Revocation and Fallback

This controller decides whether a boot image may run. A start pulse launches a validation attempt at the primary image location. For each attempt, the block requests a digest over the presented key or key list. The external hash engine returns that digest together with the image header flags: list-or-single mode, key index and keep-writable. The block compares the digest bit for bit against the 256-bit root hash held in fuses. It then checks the selected key index against a 3-bit revocation fuse field. Only when both checks succeed does it request a signature verification.

If the primary attempt is rejected at any stage, the block pulses a software-failure strobe and repeats the whole attempt once at the alternate location. An image accepted there gets exactly the same grant as a primary one. If the alternate is also rejected, the block latches a failure output until reset and never grants. Hashing and signature arithmetic live outside the block. Both are reached through valid/ready handshakes, and only one request or response is pending at any time.

Top module: `img_accept_seq`

## Requirements
- R1: After reset, granted, fail_lock, busy, hreq_valid, sreq_valid and sw_fail_strobe are all 0.
- R2: A start pulse raises hreq_valid with hreq_alt=0 (primary). hreq_valid and hreq_alt hold until hreq_ready is seen. At most one of hreq_valid, hres_ready, sreq_valid and sres_ready is high in any cycle.
- R3: An attempt passes the digest check only when all 256 bits of hres_digest equal fuse_root_hash. On a mismatch the attempt fails and no signature request is issued.
- R4: Key index k (0, 1 or 2) is revoked when fuse_revoke[k]=1. Selecting a revoked index fails the attempt even if the digest matches, and no signature request is issued. Key index 3 is never revoked, even with fuse_revoke=3'b111.
- R5: In single-key mode (hdr_is_list=0), any key index other than 0 fails the attempt.
- R6: When the digest and key checks succeed, sreq_valid is raised. A response with sres_ok=1 sets granted. grant_leave_wr then equals the hdr_leave_wr captured with that attempt's digest.
- R7: When the primary attempt fails, sw_fail_strobe is high for exactly one cycle. In that same cycle hreq_valid=1 and hreq_alt=1.
- R8: An alternate attempt is judged by the same rules. If it passes, granted=1 and grant_alt=1, with the same grant outputs as a primary pass.
- R9: When the alternate attempt also fails, sw_fail_strobe pulses again and fail_lock rises. fail_lock stays high until reset, and granted never rises.
- R10: Once granted or fail_lock is high, further start pulses change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin validation (accepted only when idle) |
| fuse_root_hash | input | 256 | Root key hash from fuses |
| fuse_revoke | input | 3 | Per-key revocation bits for keys 0..2 |
| hreq_valid | output | 1 | Digest request pending |
| hreq_ready | input | 1 | Hash engine accepts request |
| hreq_alt | output | 1 | Location of current attempt (1 = alternate) |
| hres_valid | input | 1 | Digest result and header flags valid |
| hres_ready | output | 1 | Block waits for digest result |
| hres_digest | input | 256 | Digest over presented key or key list |
| hdr_is_list | input | 1 | Header: 1 = key list, 0 = single key |
| hdr_key_idx | input | 2 | Header: selected key index |
| hdr_leave_wr | input | 1 | Header: keep-writable flag |
| sreq_valid | output | 1 | Signature check request pending |
| sreq_ready | input | 1 | Signature engine accepts request |
| sres_valid | input | 1 | Signature result valid |
| sres_ready | output | 1 | Block waits for signature result |
| sres_ok | input | 1 | Signature verified |
| busy | output | 1 | Validation in progress |
| granted | output | 1 | Image accepted (sticky) |
| grant_alt | output | 1 | Accepted image came from alternate location |
| grant_leave_wr | output | 1 | Keep-writable flag of accepted image |
| fail_lock | output | 1 | Both locations rejected (sticky) |
| sw_fail_strobe | output | 1 | One-cycle pulse per rejected attempt |

## Verification
Two events land in the same cycle: the failure strobe for a rejected primary image, and the first cycle of the alternate location's digest request. Scenarios provoke this by making the primary fail in each of the ways it can: digest mismatch, revoked index, nonzero index in single-key mode, and failed signature. In every cycle where the strobe is high, the bench also samples hreq_valid and hreq_alt. After a first failure it expects both to be high. After a second failure it expects fail_lock instead. It also counts strobes and signature handshakes per scenario against hand-derived totals.

// File: rtl/img_accept_pkg.sv
package img_accept_pkg;

    localparam int DIGEST_W  = 256;
    localparam int NUM_KEYS  = 4;
    localparam int KEY_IDX_W = $clog2(NUM_KEYS);
    localparam int REVOKE_W  = NUM_KEYS - 1;
    localparam int LANE_W    = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HREQ,
        ST_HWAIT,
        ST_SREQ,
        ST_SWAIT,
        ST_GRANT,
        ST_LOCK
    } seq_state_e;

    typedef struct packed {
        logic                 is_list;
        logic [KEY_IDX_W-1:0] key_idx;
        logic                 leave_wr;
    } img_hdr_t;

    function automatic logic idx_revoked(input logic [KEY_IDX_W-1:0] idx,
                                         input logic [REVOKE_W-1:0]  fuses);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < REVOKE_W; k++) begin
            if (idx == KEY_IDX_W'(k) && fuses[k]) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/digest_eq.sv
module digest_eq
    import img_accept_pkg::*;
#(
    parameter int WIDTH = DIGEST_W,
    parameter int LANE  = LANE_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             equal
);
    localparam int LANES = (WIDTH + LANE - 1) / LANE;
    localparam int PADW  = LANES * LANE;

    logic [PADW-1:0]  pa, pb;
    logic [LANES-1:0] lane_eq;

    assign pa = PADW'(a);
    assign pb = PADW'(b);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (pa[g*LANE +: LANE] == pb[g*LANE +: LANE]);
    end

    assign equal = &lane_eq;
endmodule

// File: rtl/key_policy.sv
module key_policy
    import img_accept_pkg::*;
(
    input  logic                 is_list,
    input  logic [KEY_IDX_W-1:0] key_idx,
    input  logic [REVOKE_W-1:0]  revoke,
    output logic                 key_ok
);
    logic revoked, mode_bad;

    assign revoked  = idx_revoked(key_idx, revoke);
    assign mode_bad = !is_list && (key_idx != '0);
    assign key_ok   = !revoked && !mode_bad;

    always_comb begin
        if (key_idx == KEY_IDX_W'(NUM_KEYS - 1) && is_list)
            AST_TOP_KEY_LIVE: assert (key_ok); // R4
    end
endmodule

// File: rtl/attempt_seq.sv
module attempt_seq
    import img_accept_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic check_ok,
    input  logic hdr_lw,
    output logic hreq_valid,
    input  logic hreq_ready,
    output logic hreq_alt,
    input  logic hres_valid,
    output logic hres_ready,
    output logic sreq_valid,
    input  logic sreq_ready,
    input  logic sres_valid,
    output logic sres_ready,
    input  logic sres_ok,
    output logic busy,
    output logic granted,
    output logic grant_alt,
    output logic grant_leave_wr,
    output logic fail_lock,
    output logic sw_fail_strobe
);
    seq_state_e state;
    logic alt_q, lw_q, strobe_q;
    logic hash_fire, sig_fire, attempt_bad;

    assign hash_fire   = (state == ST_HWAIT) && hres_valid;
    assign sig_fire    = (state == ST_SWAIT) && sres_valid;
    assign attempt_bad = (hash_fire && !check_ok) || (sig_fire && !sres_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            alt_q    <= 1'b0;
            lw_q     <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (hash_fire) lw_q <= hdr_lw;
            if (attempt_bad) begin
                strobe_q <= 1'b1;
                if (alt_q) begin
                    state <= ST_LOCK;
                end else begin
                    state <= ST_HREQ;
                    alt_q <= 1'b1;
                end
            end else begin
                unique case (state)
                    ST_IDLE:  if (start) begin
                                  state <= ST_HREQ;
                                  alt_q <= 1'b0;
                              end
                    ST_HREQ:  if (hreq_ready) state <= ST_HWAIT;
                    ST_HWAIT: if (hres_valid) state <= ST_SREQ;
                    ST_SREQ:  if (sreq_ready) state <= ST_SWAIT;
                    ST_SWAIT: if (sres_valid) state <= ST_GRANT;
                    default:  state <= state;
                endcase
            end
        end
    end

    assign hreq_valid     = (state == ST_HREQ);
    assign hres_ready     = (state == ST_HWAIT);
    assign sreq_valid     = (state == ST_SREQ);
    assign sres_ready     = (state == ST_SWAIT);
    assign hreq_alt       = alt_q;
    assign granted        = (state == ST_GRANT);
    assign fail_lock      = (state == ST_LOCK);
    assign grant_alt      = granted && alt_q;
    assign grant_leave_wr = granted && lw_q;
    assign sw_fail_strobe = strobe_q;
    assign busy           = !(state == ST_IDLE || granted || fail_lock);

    AST_ONE_PENDING: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hreq_valid, hres_ready, sreq_valid, sres_ready})); // R2
    AST_HREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        hreq_valid && !hreq_ready |=> hreq_valid && $stable(hreq_alt)); // R2
    AST_NO_SIG_ON_BAD: assert property (@(posedge clk) disable iff (rst)
        hash_fire && !check_ok |=> !sreq_valid); // R3
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
        sw_fail_strobe |=> !sw_fail_strobe); // R7
    AST_RETRY_ALT: assert property (@(posedge clk) disable iff (rst)
        sw_fail_strobe && !fail_lock |-> hreq_valid && hreq_alt); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        fail_lock |=> fail_lock && !granted); // R9
    AST_GRANT_STICKY: assert property (@(posedge clk) disable iff (rst)
        granted |=> granted && $stable(grant_alt) && $stable(grant_leave_wr)); // R10
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(granted && fail_lock)); // R9
endmodule

// File: rtl/img_accept_seq.sv
module img_accept_seq
    import img_accept_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [DIGEST_W-1:0]  fuse_root_hash,
    input  logic [REVOKE_W-1:0]  fuse_revoke,
    output logic                 hreq_valid,
    input  logic                 hreq_ready,
    output logic                 hreq_alt,
    input  logic                 hres_valid,
    output logic                 hres_ready,
    input  logic [DIGEST_W-1:0]  hres_digest,
    input  logic                 hdr_is_list,
    input  logic [KEY_IDX_W-1:0] hdr_key_idx,
    input  logic                 hdr_leave_wr,
    output logic                 sreq_valid,
    input  logic                 sreq_ready,
    input  logic                 sres_valid,
    output logic                 sres_ready,
    input  logic                 sres_ok,
    output logic                 busy,
    output logic                 granted,
    output logic                 grant_alt,
    output logic                 grant_leave_wr,
    output logic                 fail_lock,
    output logic                 sw_fail_strobe
);
    img_hdr_t hdr;
    logic     hash_match, key_ok;

    assign hdr = '{is_list: hdr_is_list, key_idx: hdr_key_idx, leave_wr: hdr_leave_wr};

    digest_eq #(.WIDTH(DIGEST_W), .LANE(LANE_W)) u_cmp (
        .a     (hres_digest),
        .b     (fuse_root_hash),
        .equal (hash_match)
    );

    key_policy u_pol (
        .is_list (hdr.is_list),
        .key_idx (hdr.key_idx),
        .revoke  (fuse_revoke),
        .key_ok  (key_ok)
    );

    attempt_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .check_ok       (hash_match && key_ok),
        .hdr_lw         (hdr.leave_wr),
        .hreq_valid     (hreq_valid),
        .hreq_ready     (hreq_ready),
        .hreq_alt       (hreq_alt),
        .hres_valid     (hres_valid),
        .hres_ready     (hres_ready),
        .sreq_valid     (sreq_valid),
        .sreq_ready     (sreq_ready),
        .sres_valid     (sres_valid),
        .sres_ready     (sres_ready),
        .sres_ok        (sres_ok),
        .busy           (busy),
        .granted        (granted),
        .grant_alt      (grant_alt),
        .grant_leave_wr (grant_leave_wr),
        .fail_lock      (fail_lock),
        .sw_fail_strobe (sw_fail_strobe)
    );

    AST_REVOKED_NO_SIG: assert property (@(posedge clk) disable iff (rst)
        hres_valid && hres_ready && hdr_is_list && hdr_key_idx != 2'd3
        && fuse_revoke[hdr_key_idx] |=> !sreq_valid); // R4
endmodule

// File: tb/sim_img_accept_seq.sv
module sim_img_accept_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // fields: rev[22:20] | p: list,key,match,sig [19:15] | a: list,key,match,sig [14:10]
    //         outcome[9:8] (0 primary, 1 alternate, 2 lock) | sreqs[7:6] | strobes[5:4]
    function automatic logic [22:0] mk(input logic [2:0] rev,
        input logic pl, input logic [1:0] pk, input logic pm, input logic ps,
        input logic al, input logic [1:0] ak, input logic am, input logic as_,
        input logic [1:0] oc, input logic [1:0] ns, input logic [1:0] nf);
        return {rev, pl, pk, pm, ps, al, ak, am, as_, oc, ns, nf, 4'b0};
    endfunction

    localparam logic [22:0] VEC [NV] = '{
        mk(3'b000, 1, 2'd2, 1, 1,  1, 2'd0, 1, 1,  2'd0, 2'd1, 2'd0), // R6 list key2
        mk(3'b000, 0, 2'd0, 1, 1,  1, 2'd0, 1, 1,  2'd0, 2'd1, 2'd0), // R6 single key0
        mk(3'b000, 0, 2'd1, 1, 1,  0, 2'd0, 1, 1,  2'd1, 2'd1, 2'd1), // R5 single nonzero
        mk(3'b100, 1, 2'd2, 1, 1,  1, 2'd3, 1, 1,  2'd1, 2'd1, 2'd1), // R4 key2 revoked
        mk(3'b111, 1, 2'd3, 1, 1,  1, 2'd0, 1, 1,  2'd0, 2'd1, 2'd0), // R4 key3 live
        mk(3'b001, 0, 2'd0, 1, 1,  1, 2'd1, 1, 1,  2'd1, 2'd1, 2'd1), // R4 key0 revoked
        mk(3'b000, 1, 2'd1, 0, 1,  1, 2'd1, 1, 0,  2'd2, 2'd1, 2'd2), // R3 then R9
        mk(3'b000, 1, 2'd0, 1, 0,  1, 2'd0, 0, 1,  2'd2, 2'd1, 2'd2), // R9
        mk(3'b010, 1, 2'd1, 1, 1,  1, 2'd1, 1, 1,  2'd2, 2'd0, 2'd2), // R4 both revoked
        mk(3'b000, 1, 2'd3, 1, 0,  1, 2'd2, 1, 1,  2'd1, 2'd2, 2'd1)  // R8
    };

    logic clk = 0, rst = 1, start = 0;
    logic [255:0] fuse_root_hash, hres_digest;
    logic [2:0] fuse_revoke;
    logic hreq_valid, hreq_ready, hreq_alt, hres_valid, hres_ready;
    logic hdr_is_list, hdr_leave_wr;
    logic [1:0] hdr_key_idx;
    logic sreq_valid, sreq_ready, sres_valid, sres_ready, sres_ok;
    logic busy, granted, grant_alt, grant_leave_wr, fail_lock, sw_fail_strobe;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    img_accept_seq u0 (.*);

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1; start = 0;
        hreq_ready = 0; hres_valid = 0; sreq_ready = 0; sres_valid = 0; sres_ok = 0;
        hres_digest = '0; hdr_is_list = 0; hdr_key_idx = 0; hdr_leave_wr = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        fuse_root_hash = {8{32'hA5C3_0F17}};
        fuse_revoke = 0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check(!granted && !fail_lock && !busy && !hreq_valid && !sreq_valid && !sw_fail_strobe,
              "R1", {granted, fail_lock, busy, hreq_valid, sreq_valid, sw_fail_strobe}, 0);
        // R2 request held while ready low
        start = 1; @(negedge clk); start = 0;
        for (int i = 0; i < 3; i++) begin
            check(hreq_valid && !hreq_alt && busy, "R2", {hreq_valid, hreq_alt}, 2);
            @(negedge clk);
        end

        for (int v = 0; v < NV; v++) begin
            logic [22:0] e;
            int ns, nf, guard;
            bit first_strobe;
            e = VEC[v];
            do_reset();
            fuse_revoke = e[22:20];
            @(negedge clk);
            start = 1; @(negedge clk); start = 0;
            ns = 0; nf = 0; guard = 0; first_strobe = 1;
            while (!granted && !fail_lock && guard < 60) begin
                logic [4:0] f;
                f = hreq_alt ? e[14:10] : e[19:15];
                if (sw_fail_strobe) begin
                    nf++;
                    if (first_strobe)
                        check(hreq_valid && hreq_alt, "R7", {hreq_valid, hreq_alt}, 3);
                    first_strobe = 0;
                end
                hreq_ready = hreq_valid;
                hres_valid = hres_ready;
                hdr_is_list = f[4];
                hdr_key_idx = f[3:2];
                hdr_leave_wr = !hreq_alt;
                hres_digest = f[1] ? fuse_root_hash : (fuse_root_hash ^ (256'd1 << 200));
                sreq_ready = sreq_valid;
                if (sreq_valid) ns++;
                sres_valid = sres_ready;
                sres_ok = f[0];
                guard++;
                @(negedge clk);
            end
            if (sw_fail_strobe) nf++;
            hreq_ready = 0; hres_valid = 0; sreq_ready = 0; sres_valid = 0;
            case (e[9:8])
                2'd0: check(granted && !grant_alt && grant_leave_wr && !fail_lock,
                            "R6", {granted, grant_alt, grant_leave_wr, fail_lock}, 4'b1010);
                2'd1: check(granted && grant_alt && !grant_leave_wr && !fail_lock,
                            "R8", {granted, grant_alt, grant_leave_wr, fail_lock}, 4'b1100);
                default: check(!granted && fail_lock,
                            "R9", {granted, fail_lock}, 1);
            endcase
            check(ns == int'(e[7:6]), "R3/R4 sig requests", ns, int'(e[7:6]));
            check(nf == int'(e[5:4]), "R7 strobes", nf, int'(e[5:4]));
            // R10 start ignored after finish
            start = 1; @(negedge clk); start = 0;
            repeat (3) @(negedge clk);
            if (e[9:8] == 2'd2)
                check(fail_lock && !granted && !hreq_valid && !sw_fail_strobe, "R9 sticky",
                      {fail_lock, granted, hreq_valid}, 4);
            else
                check(granted && !hreq_valid && !busy && grant_alt == e[8], "R10",
                      {granted, hreq_valid, busy, grant_alt}, {3'b100, e[8]});
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule